// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access may proceed against a page that has already been located in the hashed page table. It combines three independent sources of permission. The first is the protection-class code of the page entry, read through a key bit taken from the segment descriptor. The second is the entry's no-execute and guarded attributes. The third is a per-class key mask held in two 64-bit mask registers, one for data accesses and one for instruction fetches. The result is a read/write/execute permission set, a grant or deny decision for the requested access, a fault syndrome that keeps each cause apart, and two flags that say whether the entry's reference and change bits must be written back.

A request is presented with `req_valid` for one cycle, together with all descriptor, entry and register fields. The result appears registered on the next clock edge with `rsp_valid` high. Table lookup, write-back of the reference and change bits, and exception delivery are handled by the surrounding logic.

Top module: `page_perm_eval`

## Requirements
- R1: The selected key is `seg_key_user` when `user_mode` is 1 and `seg_key_super` when `user_mode` is 0.
- R2: The 3-bit protection code is {`pp_hi`, `pp_lo[1:0]`}. With key 0, codes 0, 1 and 2 give read+write+execute, and codes 3 and 6 give read+execute. With key 1, code 2 gives read+write+execute, codes 1 and 3 give read+execute, and codes 0 and 6 give nothing. Codes 4, 5 and 7 give nothing for both keys. `perm` is bit 0 read, bit 1 write, bit 2 execute.
- R3: When `no_exec` or `guarded` is 1, execute is removed and read and write are left untouched.
- R4: When `key_mask_en` is 1, the 2-bit group of `data_mask` at bit offset 2*(31-`class_key`) applies: its upper bit removes write and its lower bit removes read. When `key_mask_en` is 0, both mask registers have no effect.
- R5: When `key_mask_en` and `fetch_mask_en` are both 1, the lower bit of the same group in `fetch_mask` removes execute.
- R6: `acc_type` encodes 0 fetch, 1 load, 2 store and 3 as a load. `grant` is 1 exactly when the set formed by R2 to R5 holds execute for a fetch, read for a load, and write for a store.
- R7: For a denied fetch, syndrome bit 1 (no-execute/guard) is set when `no_exec` or `guarded` is 1. Otherwise bit 0 (protection) is set if the protection code lacks execute. Bit 2 (key mask) is set independently when the fetch mask removed execute. Bit 3 is 0.
- R8: For a denied data access, bit 0 is set if the protection code lacks the needed right, bit 2 if the key mask removed it, and bit 3 if the access is a store. A granted access has a zero syndrome.
- R9: `set_ref` is 1 when the access is granted and `ref_bit` is 0.
- R10: `set_chg` is 1 when a store is granted and `chg_bit` is 0. For any access other than a store with `chg_bit` 0, write is cleared from the returned `perm`.
- R11: Results appear one clock edge after the request, with `rsp_valid` a one-cycle delayed copy of `req_valid`. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| acc_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| user_mode | input | 1 | 1 for problem (user) state |
| seg_key_user | input | 1 | Segment key used in user mode |
| seg_key_super | input | 1 | Segment key used in supervisor mode |
| pp_lo | input | 2 | Low two protection-code bits of the entry |
| pp_hi | input | 1 | High protection-code bit of the entry |
| no_exec | input | 1 | Entry no-execute attribute |
| guarded | input | 1 | Entry guarded attribute |
| class_key | input | 5 | Entry class key |
| data_mask | input | 64 | Data key-mask register |
| fetch_mask | input | 64 | Instruction key-mask register |
| key_mask_en | input | 1 | Enables key-mask checking |
| fetch_mask_en | input | 1 | Enables the instruction key mask |
| ref_bit | input | 1 | Current reference bit of the entry |
| chg_bit | input | 1 | Current change bit of the entry |
| rsp_valid | output | 1 | Result valid |
| perm | output | 3 | Returned permission set {X, W, R} |
| grant | output | 1 | Access allowed |
| syndrome | output | 4 | {store, key mask, no-exec/guard, protection} |
| set_ref | output | 1 | Reference bit must be set |
| set_chg | output | 1 | Change bit must be set |

## Verification
The assertions assume that every input field is held stable and known for the cycle in which `req_valid` is high. They also assume that `req_valid` stays low while reset is asserted, so the one-cycle valid relation holds from the first edge. The directed tasks drive all fields on the falling edge, keep them fixed through the capturing edge, and raise `req_valid` only after reset is released. Code 3 of `acc_type` is used only in its own scenario, where it is checked against load behaviour.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;
  localparam int KEY_W   = 5;
  localparam int NCLASS  = 1 << KEY_W;
  localparam int MASK_W  = 2 * NCLASS;
  localparam int PERM_W  = 3;
  localparam int SYN_W   = 4;

  localparam int P_RD = 0;
  localparam int P_WR = 1;
  localparam int P_EX = 2;

  localparam int S_PROT  = 0;
  localparam int S_NXG   = 1;
  localparam int S_KEY   = 2;
  localparam int S_STORE = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  function automatic logic [PERM_W-1:0] pp_to_perm(input logic key, input logic [2:0] code);
    logic [PERM_W-1:0] p;
    p = '0;
    if (!key) begin
      unique case (code)
        3'd0, 3'd1, 3'd2: p = 3'b111;
        3'd3, 3'd6:       p = 3'b101;
        default:          p = 3'b000;
      endcase
    end else begin
      unique case (code)
        3'd2:       p = 3'b111;
        3'd1, 3'd3: p = 3'b101;
        default:    p = 3'b000;
      endcase
    end
    return p;
  endfunction

  function automatic logic [1:0] mask_group(input logic [MASK_W-1:0] mreg, input logic [KEY_W-1:0] key);
    int unsigned off;
    off = 2 * (NCLASS - 1 - int'(key));
    return 2'(mreg >> off);
  endfunction

  function automatic int unsigned need_bit(input acc_e a);
    unique case (a)
      ACC_FETCH: return P_EX;
      ACC_STORE: return P_WR;
      default:   return P_RD;
    endcase
  endfunction
endpackage

// File: rtl/page_perm_pp.sv
module page_perm_pp
  import page_perm_pkg::*;
(
  input  logic              user_mode,
  input  logic              seg_key_user,
  input  logic              seg_key_super,
  input  logic [1:0]        pp_lo,
  input  logic              pp_hi,
  input  logic              no_exec,
  input  logic              guarded,
  output logic [PERM_W-1:0] pp_perm,
  output logic [PERM_W-1:0] nxg_perm,
  output logic              nxg_hit
);
  logic key_sel;

  always_comb begin
    key_sel  = user_mode ? seg_key_user : seg_key_super;
    pp_perm  = pp_to_perm(key_sel, {pp_hi, pp_lo});
    nxg_hit  = no_exec | guarded;
    nxg_perm = 3'b111;
    if (nxg_hit) nxg_perm[P_EX] = 1'b0;
  end
endmodule

// File: rtl/page_perm_mask.sv
module page_perm_mask
  import page_perm_pkg::*;
(
  input  logic [KEY_W-1:0]  class_key,
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] fetch_mask,
  input  logic              key_mask_en,
  input  logic              fetch_mask_en,
  output logic [PERM_W-1:0] mask_perm
);
  logic [1:0] dgrp;
  logic [1:0] fgrp;

  always_comb begin
    dgrp      = mask_group(data_mask, class_key);
    fgrp      = mask_group(fetch_mask, class_key);
    mask_perm = 3'b111;
    if (key_mask_en) begin
      if (dgrp[1]) mask_perm[P_WR] = 1'b0;
      if (dgrp[0]) mask_perm[P_RD] = 1'b0;
      if (fetch_mask_en && fgrp[0]) mask_perm[P_EX] = 1'b0;
    end
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import page_perm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_type,
  input  logic              user_mode,
  input  logic              seg_key_user,
  input  logic              seg_key_super,
  input  logic [1:0]        pp_lo,
  input  logic              pp_hi,
  input  logic              no_exec,
  input  logic              guarded,
  input  logic [KEY_W-1:0]  class_key,
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] fetch_mask,
  input  logic              key_mask_en,
  input  logic              fetch_mask_en,
  input  logic              ref_bit,
  input  logic              chg_bit,
  output logic              rsp_valid,
  output logic [PERM_W-1:0] perm,
  output logic              grant,
  output logic [SYN_W-1:0]  syndrome,
  output logic              set_ref,
  output logic              set_chg
);
  logic [PERM_W-1:0] pp_perm, nxg_perm, mask_perm, raw_perm, ret_perm;
  logic              nxg_hit, is_fetch, is_store, ok;
  logic [SYN_W-1:0]  syn_d;
  int unsigned       nb;
  acc_e              acc;
  acc_e              acc_q;

  page_perm_pp u_pp (
    .user_mode    (user_mode),
    .seg_key_user (seg_key_user),
    .seg_key_super(seg_key_super),
    .pp_lo        (pp_lo),
    .pp_hi        (pp_hi),
    .no_exec      (no_exec),
    .guarded      (guarded),
    .pp_perm      (pp_perm),
    .nxg_perm     (nxg_perm),
    .nxg_hit      (nxg_hit)
  );

  page_perm_mask u_mask (
    .class_key    (class_key),
    .data_mask    (data_mask),
    .fetch_mask   (fetch_mask),
    .key_mask_en  (key_mask_en),
    .fetch_mask_en(fetch_mask_en),
    .mask_perm    (mask_perm)
  );

  always_comb begin
    acc      = acc_e'(acc_type);
    is_fetch = (acc == ACC_FETCH);
    is_store = (acc == ACC_STORE);
    nb       = need_bit(acc);
    raw_perm = pp_perm & nxg_perm & mask_perm;
    ok       = raw_perm[nb];
    ret_perm = raw_perm;
    if (!chg_bit && !is_store) ret_perm[P_WR] = 1'b0;
    syn_d = '0;
    if (!ok) begin
      if (is_fetch) begin
        syn_d[S_NXG]  = nxg_hit;
        syn_d[S_PROT] = !nxg_hit && !pp_perm[P_EX];
        syn_d[S_KEY]  = !mask_perm[P_EX];
      end else begin
        syn_d[S_PROT]  = !pp_perm[nb];
        syn_d[S_KEY]   = !mask_perm[nb];
        syn_d[S_STORE] = is_store;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      perm      <= '0;
      grant     <= 1'b0;
      syndrome  <= '0;
      set_ref   <= 1'b0;
      set_chg   <= 1'b0;
      acc_q     <= ACC_FETCH;
    end else begin
      rsp_valid <= req_valid;
      perm      <= ret_perm;
      grant     <= ok;
      syndrome  <= syn_d;
      set_ref   <= ok && !ref_bit;
      set_chg   <= ok && is_store && !chg_bit;
      acc_q     <= acc;
    end
  end
endmodule

// File: rtl/page_perm_eval_chk.sv
module page_perm_eval_chk
  import page_perm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input acc_e              acc_q,
  input logic [PERM_W-1:0] perm,
  input logic              grant,
  input logic [SYN_W-1:0]  syndrome,
  input logic              set_ref,
  input logic              set_chg
);
  p_valid_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_clean_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && grant) |-> (syndrome == '0));

  p_deny_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !grant) |-> (syndrome != '0));

  p_fetch_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && acc_q == ACC_FETCH) |-> ($onehot0(syndrome[1:0]) && !syndrome[S_STORE]));

  p_store_grant_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && grant && acc_q == ACC_STORE) |-> perm[P_WR]);

  p_fetch_grant_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && grant && acc_q == ACC_FETCH) |-> perm[P_EX]);

  p_chg_only_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_chg |-> (grant && acc_q == ACC_STORE));

  p_ref_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ref |-> grant);
endmodule

bind page_perm_eval page_perm_eval_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .rsp_valid(rsp_valid),
  .acc_q    (acc_q),
  .perm     (perm),
  .grant    (grant),
  .syndrome (syndrome),
  .set_ref  (set_ref),
  .set_chg  (set_chg)
);

// File: tb/test_page_perm_eval.sv
`timescale 1ns/1ps
module test_page_perm_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_type = 2'd1;
  logic        user_mode = 1'b0, seg_key_user = 1'b0, seg_key_super = 1'b0;
  logic [1:0]  pp_lo = 2'd0;
  logic        pp_hi = 1'b0, no_exec = 1'b0, guarded = 1'b0;
  logic [4:0]  class_key = 5'd0;
  logic [63:0] data_mask = '0, fetch_mask = '0;
  logic        key_mask_en = 1'b0, fetch_mask_en = 1'b0;
  logic        ref_bit = 1'b1, chg_bit = 1'b1;
  logic        rsp_valid, grant, set_ref, set_chg;
  logic [2:0]  perm;
  logic [3:0]  syndrome;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  page_perm_eval i_page_perm_eval (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
    .user_mode(user_mode), .seg_key_user(seg_key_user), .seg_key_super(seg_key_super),
    .pp_lo(pp_lo), .pp_hi(pp_hi), .no_exec(no_exec), .guarded(guarded),
    .class_key(class_key), .data_mask(data_mask), .fetch_mask(fetch_mask),
    .key_mask_en(key_mask_en), .fetch_mask_en(fetch_mask_en),
    .ref_bit(ref_bit), .chg_bit(chg_bit),
    .rsp_valid(rsp_valid), .perm(perm), .grant(grant), .syndrome(syndrome),
    .set_ref(set_ref), .set_chg(set_chg)
  );

  // Bench model written from the requirements
  task automatic model(output logic [2:0] ep, output logic eg, output logic [3:0] es,
                       output logic er, output logic ec);
    logic k, r, w, x, pr, pw, px, mr, mw, mx, nr;
    int c, base;
    k = user_mode ? seg_key_user : seg_key_super;                      // R1
    c = {pp_hi, pp_lo};                                                // R2
    pr = k ? (c == 1 || c == 2 || c == 3) : (c <= 3 || c == 6);
    pw = k ? (c == 2) : (c <= 2);
    px = pr;
    base = 62 - 2 * class_key;                                         // R4
    mr = !(key_mask_en && data_mask[base]);
    mw = !(key_mask_en && data_mask[base + 1]);
    mx = !(key_mask_en && fetch_mask_en && fetch_mask[base]);          // R5
    r = pr && mr;
    w = pw && mw;
    x = px && mx && !(no_exec || guarded);                             // R3
    case (acc_type)                                                    // R6
      2'd0:    nr = x;
      2'd2:    nr = w;
      default: nr = r;
    endcase
    eg = nr;
    ep = {x, (acc_type == 2'd2 || chg_bit) ? w : 1'b0, r};             // R10
    es = 4'd0;
    if (!eg) begin
      if (acc_type == 2'd0) begin                                      // R7
        es[1] = no_exec || guarded;
        es[0] = !(no_exec || guarded) && !px;
        es[2] = !mx;
      end else begin                                                   // R8
        es[0] = (acc_type == 2'd2) ? !pw : !pr;
        es[2] = (acc_type == 2'd2) ? !mw : !mr;
        es[3] = (acc_type == 2'd2);
      end
    end
    er = eg && !ref_bit;                                               // R9
    ec = eg && acc_type == 2'd2 && !chg_bit;
  endtask

  task automatic do_check(input string tag);
    logic [2:0] ep; logic eg; logic [3:0] es; logic er, ec;
    model(ep, eg, es, er, ec);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (!(rsp_valid === 1'b1 && perm === ep && grant === eg && syndrome === es &&
          set_ref === er && set_chg === ec)) begin
      fails++;
      $display("FAIL %s: actual v=%b p=%b g=%b s=%b r=%b c=%b expected v=1 p=%b g=%b s=%b r=%b c=%b",
               tag, rsp_valid, perm, grant, syndrome, set_ref, set_chg, ep, eg, es, er, ec);
    end
  endtask

  task automatic clear_inputs();
    acc_type = 2'd1; user_mode = 0; seg_key_user = 0; seg_key_super = 0;
    pp_lo = 0; pp_hi = 0; no_exec = 0; guarded = 0; class_key = 0;
    data_mask = '0; fetch_mask = '0; key_mask_en = 0; fetch_mask_en = 0;
    ref_bit = 1; chg_bit = 1;
  endtask

  task automatic t_reset();
    checks++;
    if ({rsp_valid, perm, grant, syndrome, set_ref, set_chg} !== '0) begin
      fails++;
      $display("FAIL R11 reset: actual %b expected 0",
               {rsp_valid, perm, grant, syndrome, set_ref, set_chg});
    end
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle valid: actual %b expected 0", rsp_valid);
    end
  endtask

  task automatic t_pp_table();
    for (int um = 0; um < 2; um++)
      for (int kk = 0; kk < 2; kk++)
        for (int c = 0; c < 8; c++) begin
          clear_inputs();
          user_mode = um[0];
          seg_key_user = kk[0]; seg_key_super = ~kk[0];
          {pp_hi, pp_lo} = c[2:0];
          acc_type = 2'd1;
          do_check("R1 R2 table load");
          acc_type = 2'd2;
          do_check("R2 table store");
        end
  endtask

  task automatic t_nxg();
    clear_inputs(); acc_type = 2'd0; no_exec = 1;
    do_check("R3 R7 noexec fetch");
    clear_inputs(); acc_type = 2'd1; guarded = 1;
    do_check("R3 guarded load kept");
    clear_inputs(); acc_type = 2'd0; guarded = 1; pp_hi = 1; pp_lo = 2'd0;
    do_check("R7 guard over prot");
    clear_inputs(); acc_type = 2'd0; pp_hi = 1; pp_lo = 2'd1;
    do_check("R7 prot fetch");
  endtask

  task automatic t_key_mask();
    clear_inputs(); key_mask_en = 1; class_key = 5'd5; data_mask[63 - 10] = 1'b1;
    acc_type = 2'd2; do_check("R4 R8 mask write store");
    acc_type = 2'd1; do_check("R4 load unaffected by write mask");
    clear_inputs(); key_mask_en = 1; class_key = 5'd31; data_mask[0] = 1'b1;
    acc_type = 2'd1; do_check("R4 mask read key31");
    clear_inputs(); key_mask_en = 1; class_key = 5'd0; data_mask[63:62] = 2'b11;
    acc_type = 2'd2; seg_key_super = 1; pp_lo = 2'd1;
    do_check("R8 store prot and key");
    clear_inputs(); key_mask_en = 0; data_mask = '1; fetch_mask = '1; fetch_mask_en = 1;
    acc_type = 2'd2; do_check("R4 disabled store");
    acc_type = 2'd0; do_check("R4 disabled fetch");
  endtask

  task automatic t_fetch_mask();
    clear_inputs(); key_mask_en = 1; fetch_mask_en = 1; class_key = 5'd7;
    fetch_mask[62 - 14] = 1'b1; acc_type = 2'd0;
    do_check("R5 R7 fetch mask");
    no_exec = 1; do_check("R7 nx plus key");
    clear_inputs(); key_mask_en = 1; fetch_mask_en = 0; class_key = 5'd7;
    fetch_mask[62 - 14] = 1'b1; acc_type = 2'd0;
    do_check("R5 fetch mask off");
    clear_inputs(); key_mask_en = 1; fetch_mask_en = 1; class_key = 5'd7;
    fetch_mask[63 - 14] = 1'b1; acc_type = 2'd0;
    do_check("R5 upper bit no exec effect");
  endtask

  task automatic t_ref_chg();
    clear_inputs(); ref_bit = 0; chg_bit = 0; acc_type = 2'd1;
    do_check("R9 R10 load clears write");
    acc_type = 2'd2; do_check("R10 store sets change");
    acc_type = 2'd0; do_check("R9 fetch ref");
    pp_hi = 1; pp_lo = 2'd0; acc_type = 2'd2;
    do_check("R9 denied no ref");
    clear_inputs(); ref_bit = 1; chg_bit = 1; acc_type = 2'd2;
    do_check("R10 both set");
  endtask

  task automatic t_acc3();
    clear_inputs(); acc_type = 2'd3; seg_key_super = 1; pp_lo = 2'd3;
    do_check("R6 code3 as load");
    pp_lo = 2'd0; do_check("R6 code3 denied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pp_table();
    t_nxg();
    t_key_mask();
    t_fetch_mask();
    t_ref_chg();
    t_acc3();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule